// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes a 16-bit check value over a block of 32-bit quadlets, for example a topology map image or a speed map image that is about to be published. A caller pulses `start` with the number of quadlets in the block. It then offers the quadlets one at a time on a valid/ready handshake. The engine folds each accepted quadlet into the check four bits per clock, starting with the most significant nibble. When the last quadlet has been folded in, it raises `done` and presents the 16-bit result.

The check register is cleared at every accepted start. At each step a 4-bit sum is formed from the top nibble of the check and the incoming nibble. The new check is the old check shifted left by four, with the sum fed back at bit positions 12, 5 and 0. The quadlet count comes from the caller, because the covered length depends on the image: a topology image covers its self-ID count plus two, and a speed image covers 0x3f1 quadlets.

Top module: `qcrc16_engine`

## Requirements
- R1: After reset, `busy`, `done` and `in_ready` are 0 and `crc_out` is 0x0000.
- R2: A `start` pulse with a nonzero `qcount`, sampled while `busy` is 0, makes `busy` 1 and `in_ready` 1 from the next clock, clears `done` and starts the check from 0x0000.
- R3: Each quadlet is consumed as eight nibbles, bits 31..28 first and bits 3..0 last.
- R4: Per nibble n, with check c: s = (c[15:12] XOR n) & 0xF, and next c = ((c<<4) XOR (s<<12) XOR (s<<5) XOR s) & 0xFFFF.
- R5: A quadlet is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly 8 clocks and returns to 1 when another quadlet of the block remains.
- R6: After the 8th clock of the last quadlet, `done` is 1, `busy` is 0, `in_ready` is 0 and `crc_out` holds the check of the whole block.
- R7: A `start` with `qcount` = 0, sampled while idle, raises `done` on the next clock with `crc_out` = 0x0000, and `busy` stays 0.
- R8: A `start` pulse sampled while `busy` is 1 is ignored. The running block finishes with its original count and value.
- R9: `done` and `crc_out` stay unchanged until the next accepted `start`, which clears `done`.
- R10: `in_valid` and `in_data` presented while `in_ready` is 0 are ignored and do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a new block (one-cycle pulse) |
| qcount | input | CNT_W | Number of quadlets in the block |
| in_valid | input | 1 | Quadlet offered on in_data |
| in_data | input | 32 | Quadlet, bit 31 is most significant |
| in_ready | output | 1 | Engine can take a quadlet this cycle |
| busy | output | 1 | A block is in progress |
| done | output | 1 | Result valid on crc_out |
| crc_out | output | 16 | Check value of the last block |

## Verification
The hardest situation to reach from the ports is a `start` or a stray `in_valid` arriving in the middle of the eight-clock nibble walk. The behaviour there looks the same at the ports whether or not the stimulus was taken. The bench therefore reaches this case indirectly. It drives junk quadlets with `in_valid` high during every busy clock of some blocks, and it pulses `start` with a different count partway through others. A stolen quadlet or a restarted count would then show up as a wrong final check, a wrong clock count, or `done` arriving at the wrong time. Single-quadlet blocks sweep every nonzero nibble value through every nibble position, which pins down both the nibble order and the feedback taps.

// File: rtl/qcrc16_pkg.sv
package qcrc16_pkg;
  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;
  localparam int CRC_W  = 16;
  localparam int NIBS_PER_WORD = WORD_W / NIB_W;
  localparam int NIB_IDX_W = $clog2(NIBS_PER_WORD);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_RUN  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/qcrc16_step.sv
module qcrc16_step
  import qcrc16_pkg::*;
(
  input  logic [CRC_W-1:0] chk_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic [CRC_W-1:0] chk_out
);
  logic [NIB_W-1:0] fold;

  always_comb begin
    fold    = chk_in[CRC_W-1 -: NIB_W] ^ nib_in;
    chk_out = {chk_in[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}}
            ^ {fold, 12'h000}
            ^ {7'b0, fold, 5'b0}
            ^ {12'h000, fold};
  end
endmodule

// File: rtl/qcrc16_ctrl.sv
module qcrc16_ctrl
  import qcrc16_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] qcount,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic             clr_en,
  output logic             load_en,
  output logic             step_en
);
  localparam logic [NIB_IDX_W-1:0] LAST_NIB = NIB_IDX_W'(NIBS_PER_WORD - 1);

  eng_state_t             st_q, st_d;
  logic [CNT_W-1:0]       rem_q, rem_d;
  logic [NIB_IDX_W-1:0]   nib_q, nib_d;
  logic                   done_q, done_d;

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    nib_d   = nib_q;
    done_d  = done_q;
    clr_en  = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          clr_en = 1'b1;
          if (qcount == '0) begin
            done_d = 1'b1;
          end else begin
            done_d = 1'b0;
            rem_d  = qcount;
            st_d   = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (in_valid) begin
          load_en = 1'b1;
          nib_d   = '0;
          st_d    = S_RUN;
        end
      end
      S_RUN: begin
        step_en = 1'b1;
        nib_d   = nib_q + 1'b1;
        if (nib_q == LAST_NIB) begin
          rem_d = rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = S_WAIT;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      nib_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      nib_q  <= nib_d;
      done_q <= done_d;
    end
  end

  assign in_ready = (st_q == S_WAIT);
  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && nib_q != LAST_NIB) |=> (st_q == S_RUN));

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && qcount == '0) |=> (done && !busy));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == S_WAIT) |=> busy);
endmodule

// File: rtl/qcrc16_dp.sv
module qcrc16_dp
  import qcrc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [WORD_W-1:0] in_data,
  output logic [CRC_W-1:0]  chk
);
  logic [WORD_W-1:0] word_q, word_d;
  logic [CRC_W-1:0]  chk_q, chk_d;
  logic [CRC_W-1:0]  chk_next;

  qcrc16_step u_step (
    .chk_in  (chk_q),
    .nib_in  (word_q[WORD_W-1 -: NIB_W]),
    .chk_out (chk_next)
  );

  always_comb begin
    word_d = word_q;
    chk_d  = chk_q;
    if (clr_en)  chk_d = '0;
    if (load_en) word_d = in_data;
    if (step_en) begin
      chk_d  = chk_next;
      word_d = {word_q[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      chk_q  <= '0;
    end else begin
      word_q <= word_d;
      chk_q  <= chk_d;
    end
  end

  assign chk = chk_q;

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !clr_en) |=> $stable(chk_q));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (chk_q == '0));
endmodule

// File: rtl/qcrc16_engine.sv
module qcrc16_engine
  import qcrc16_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] qcount,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic [15:0]      crc_out
);
  logic clr_en, load_en, step_en;

  qcrc16_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .qcount   (qcount),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .clr_en   (clr_en),
    .load_en  (load_en),
    .step_en  (step_en)
  );

  qcrc16_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .load_en (load_en),
    .step_en (step_en),
    .in_data (in_data),
    .chk     (crc_out)
  );

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(crc_out)));
endmodule

// File: tb/qcrc16_engine_tb.sv
module qcrc16_engine_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] qcount = '0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  logic             in_ready, busy, done;
  logic [15:0]      crc_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] blk [0:15];
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  qcrc16_engine #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .qcount(qcount),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy(busy), .done(done), .crc_out(crc_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    int c = 0;
    for (int q = 0; q < n; q++) begin
      for (int p = 7; p >= 0; p--) begin
        int s = ((c >> 12) ^ (int'(blk[q]) >>> (4 * p))) & 15;
        c = ((c * 16) ^ (s * 4096) ^ (s * 32) ^ s) & 16'hFFFF;
      end
    end
    return c[15:0];
  endfunction

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic run_block(input int n, input bit junk, input bit stray, input int gap);
    int cnt;
    logic [15:0] exp;
    logic [15:0] held;
    exp = ref_crc(n);
    @(negedge clk);
    start = 1'b1; qcount = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {31'b0, busy}, 32'd1);
    chk("R2 done cleared", {31'b0, done}, 32'd0);
    for (int q = 0; q < n; q++) begin
      for (int g = 0; g < gap; g++) begin
        chk("R5 ready while waiting", {31'b0, in_ready}, 32'd1);
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = blk[q];
      @(negedge clk);
      in_valid = 1'b0;
      cnt = 0;
      while (!in_ready && !done && cnt < 20) begin
        cnt++;
        in_valid = junk;
        in_data = next_rand();
        if (stray && cnt == 3) begin
          start = 1'b1; qcount = CNT_W'(5);
        end
        @(negedge clk);
        start = 1'b0;
      end
      in_valid = 1'b0;
      chk("R5 eight clocks per quadlet", cnt, 32'd8);
    end
    chk("R6 done after last quadlet", {31'b0, done}, 32'd1);
    chk("R6 busy low at end", {31'b0, busy}, 32'd0);
    chk("R6 ready low at end", {31'b0, in_ready}, 32'd0);
    chk("R4 R3 R8 R10 block check value", {16'b0, crc_out}, {16'b0, exp});
    held = crc_out;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_data = next_rand();
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R9 result held", {16'b0, crc_out}, {16'b0, held});
    chk("R9 done held", {31'b0, done}, 32'd1);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", {31'b0, busy}, 32'd0);
    chk("R1 done reset", {31'b0, done}, 32'd0);
    chk("R1 ready reset", {31'b0, in_ready}, 32'd0);
    chk("R1 crc reset", {16'b0, crc_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: zero count
    start = 1'b1; qcount = '0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done on zero count", {31'b0, done}, 32'd1);
    chk("R7 zero result", {16'b0, crc_out}, 32'd0);
    chk("R7 not busy", {31'b0, busy}, 32'd0);

    // R3/R4: every nonzero nibble in every position, single quadlet
    for (int p = 0; p < 8; p++) begin
      for (int v = 1; v < 16; v++) begin
        blk[0] = 32'(v) << (4 * p);
        run_block(1, 1'b0, 1'b0, 0);
      end
    end

    // R8/R10: multi-quadlet blocks with junk valid and stray start
    for (int n = 1; n <= 15; n++) begin
      for (int q = 0; q < 16; q++) blk[q] = next_rand();
      run_block(n, n % 2 == 1, n % 3 == 0, n % 4);
    end

    // R7 after a finished block: zero count clears the result
    start = 1'b1; qcount = '0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 zero count after block", {16'b0, crc_out}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule